// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial Inner Product Engine

This block forms the dot product of N signed samples with N constant weights, using no multiplier. The weights are fixed by a parameter. At elaboration time a table with 2^N entries is built. Each entry holds the sum of the weights whose select bits are set in that entry's index. A computation starts when a strobe loads all N samples at once. After that the engine visits one bit position per clock, lowest first. The bits of equal weight taken from every sample together form the table index. The value read from the table is folded into a two-part accumulator that shifts right one place per clock. The high part holds the running partial sum. The low part collects the bits that shift out, so no precision is lost.

In two's complement the top bit of a sample has a negative weight. For that reason the table value read on the final bit position is subtracted, and every other value is added. A busy flag covers the computation. A one-cycle done strobe marks the moment the full-width result is valid. The result then stays on its port until the next accepted start.

Top module: `da_inner_product`

## Requirements
- R1: After synchronous active-high reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: A start accepted at a clock edge sets `busy` from that edge on. `done` goes high exactly B clock edges later, stays high for one cycle only, and `busy` is low while `done` is high.
- R3: `result` equals the signed sum over all lanes of sample[i] times weight[i], held at full precision. With 8 lanes, 8-bit samples and 10-bit weights the result is 21 bits wide, which is enough for any input combination.
- R4: Samples are two's complement, so bit B-1 carries weight -2^(B-1). The case where every sample holds the most negative value gives -2^(B-1) times the sum of the weights.
- R5: A start strobe that arrives while `busy` is high is ignored. It produces no extra `done`, does not alter the running result, and does not move the `done` of the computation in progress.
- R6: After `done`, `result` keeps its value until the next accepted start, whatever the sample inputs do.
- R7: Sample i is taken from `samples[i*B +: B]` and is paired with the weight at `COEFS[i*CW +: CW]`. Both are two's complement.
- R8: Samples are captured only at an accepted start. Changing `samples` while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation when idle |
| samples | input | N*B | Packed signed samples, lane 0 in the low bits |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe: `result` valid |
| result | output | B+CW+log2(N) | Signed inner product |

## Verification
On every cycle, assertions check four things. `done` lasts one cycle and follows the final bit position. A start during a run neither ends it nor raises `done`. The accumulator's high part never leaves its proven range. Idle state does not disturb the captured samples or the held result. Arithmetic correctness cannot be seen from one cycle to the next, so only the bench scenarios show it. These cover most-negative samples, most-positive samples and mixed-sign extremes. Random vectors are compared against a directly computed sum of products. Samples are disturbed and starts repeated in the middle of a run. The result is watched while the block sits idle.

// File: rtl/da_pkg.sv
package da_pkg;
    localparam int DA_LANES = 8;
    localparam int DA_SBITS = 8;
    localparam int DA_CBITS = 10;
    localparam logic [DA_LANES*DA_CBITS-1:0] DA_WEIGHTS =
        {10'h12C, 10'h3FF, 10'h0FF, 10'h000, 10'h200, 10'h1FF, 10'h39C, 10'h025};

    typedef enum logic {ST_IDLE, ST_RUN} da_state_e;

    typedef struct packed {
        logic step;     // fold one bit plane this cycle
        logic neg;      // this plane carries negative weight
        logic last;     // final plane of the run
    } da_step_t;

    // width of one table word: sum of lanes weights, signed
    function automatic int tbl_width(int lanes, int cbits);
        return cbits + $clog2(lanes);
    endfunction
endpackage

// File: rtl/da_ctrl.sv
module da_ctrl
    import da_pkg::*;
#(
    parameter int B = DA_SBITS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     load,
    output logic     busy,
    output logic     done,
    output da_step_t step
);
    localparam int CNTW = (B > 1) ? $clog2(B) : 1;
    localparam logic [CNTW-1:0] LAST_IDX = CNTW'(B - 1);

    da_state_e      state_q;
    logic [CNTW-1:0] cnt_q;
    logic           done_q;

    assign load      = start && (state_q == ST_IDLE);
    assign busy      = (state_q == ST_RUN);
    assign done      = done_q;
    assign step.step = busy;
    assign step.neg  = busy && (cnt_q == LAST_IDX);
    assign step.last = busy && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    if (cnt_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: done is a single-cycle strobe
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: the final plane is followed by done
    p_last_done_r2: assert property (@(posedge clk) disable iff (rst)
        step.last |=> done);
    // R5: a start during a run keeps the run going and raises no done
    p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !step.last) |=> (busy && !done));
endmodule

// File: rtl/da_bitplane.sv
module da_bitplane #(
    parameter int N = da_pkg::DA_LANES,
    parameter int B = da_pkg::DA_SBITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [N*B-1:0] samples,
    output logic [N-1:0] addr
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [B-1:0] sr_q;
        always_ff @(posedge clk) begin
            if (rst)        sr_q <= '0;
            else if (load)  sr_q <= samples[i*B +: B];
            else if (shift) sr_q <= {1'b0, sr_q[B-1:1]};
        end
        assign addr[i] = sr_q[0];
    end

    // R8: outside load and shift the captured planes do not move
    p_hold_planes_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(addr));
endmodule

// File: rtl/da_rom.sv
module da_rom #(
    parameter int N  = da_pkg::DA_LANES,
    parameter int CW = da_pkg::DA_CBITS,
    parameter logic [N*CW-1:0] COEFS = da_pkg::DA_WEIGHTS,
    localparam int RMW = da_pkg::tbl_width(N, CW)
) (
    input  logic [N-1:0]           addr,
    output logic signed [RMW-1:0]  data
);
    localparam int DEPTH = 2 ** N;

    function automatic logic signed [RMW-1:0] entry_val(int unsigned idx);
        logic [N-1:0]          sel;
        logic signed [RMW-1:0] acc;
        sel = N'(idx);
        acc = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i])
                acc = acc + {{(RMW-CW){COEFS[i*CW+CW-1]}}, COEFS[i*CW +: CW]};
        end
        return acc;
    endfunction

    logic signed [RMW-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam logic signed [RMW-1:0] VAL = entry_val(a);
        assign tbl[a] = VAL;
    end

    assign data = tbl[addr];
endmodule

// File: rtl/da_accum.sv
module da_accum #(
    parameter int RMW = 13,
    parameter int B   = da_pkg::DA_SBITS,
    localparam int HW = RMW + 1,
    localparam int RW = HW + B - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  step,
    input  logic                  neg,
    input  logic signed [RMW-1:0] rom_val,
    output logic signed [RW-1:0]  result
);
    localparam int SW     = HW + 1;
    localparam int HI_LIM = 2 ** (RMW - 1);

    logic signed [HW-1:0] hi_q;
    logic [B-1:0]         lo_q;
    logic signed [SW-1:0] term, sum;
    logic [HW+B-1:0]      joined;

    always_comb begin
        term = {{(SW-RMW){rom_val[RMW-1]}}, rom_val};
        if (neg) term = -term;
        sum = {hi_q[HW-1], hi_q} + term;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (step) begin
            hi_q <= sum[SW-1:1];
            lo_q <= {sum[0], lo_q[B-1:1]};
        end
    end

    assign joined = {hi_q, lo_q};
    assign result = joined[RW-1:0];

    // R3: the partial sum stays inside the range its width was sized for
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(hi_q) <= HI_LIM) && (int'(hi_q) >= -HI_LIM));
    // R6: without step or clear the result holds
    p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(result));
endmodule

// File: rtl/da_inner_product.sv
module da_inner_product
    import da_pkg::*;
#(
    parameter int N  = DA_LANES,
    parameter int B  = DA_SBITS,
    parameter int CW = DA_CBITS,
    parameter logic [N*CW-1:0] COEFS = DA_WEIGHTS,
    localparam int RMW = tbl_width(N, CW),
    localparam int RW  = RMW + B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [N*B-1:0]       samples,
    output logic                 busy,
    output logic                 done,
    output logic signed [RW-1:0] result
);
    da_step_t              step;
    logic                  load;
    logic [N-1:0]          addr;
    logic signed [RMW-1:0] rom_val;

    da_ctrl #(.B(B)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .busy(busy), .done(done), .step(step)
    );

    da_bitplane #(.N(N), .B(B)) u_planes (
        .clk(clk), .rst(rst), .load(load), .shift(step.step),
        .samples(samples), .addr(addr)
    );

    da_rom #(.N(N), .CW(CW), .COEFS(COEFS)) u_rom (
        .addr(addr), .data(rom_val)
    );

    da_accum #(.RMW(RMW), .B(B)) u_acc (
        .clk(clk), .rst(rst), .clear(load), .step(step.step),
        .neg(step.neg), .rom_val(rom_val), .result(result)
    );

    // R2: result strobe and busy never overlap
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/da_inner_product_tb.sv
module da_inner_product_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8, B = 8, CW = 10, RW = 21;
    localparam logic [N*CW-1:0] TB_COEFS =
        {10'h12C, 10'h3FF, 10'h0FF, 10'h000, 10'h200, 10'h1FF, 10'h39C, 10'h025};
    localparam int W [N] = '{37, -100, 511, -512, 0, 255, -1, 300};

    logic clk = 0, rst = 1, start = 0;
    logic [N*B-1:0] samples = '0;
    logic busy, done;
    logic signed [RW-1:0] result;

    int n_chk = 0, n_fail = 0, last_exp = 0;
    int exp_q [$];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_inner_product #(.N(N), .B(B), .CW(CW), .COEFS(TB_COEFS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .samples(samples),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_dot(input logic [N*B-1:0] s);
        int acc = 0;
        for (int i = 0; i < N; i++)
            acc += int'($signed(s[i*B +: B])) * W[i];
        return acc;
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: pop expected result on every done
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0)
                check("R5 unexpected done", 1, 0);
            else
                check("R3 result", int'(result), exp_q.pop_front());
        end
    end

    // driver: push expected, strobe start, check timing (R2); poke mid-run if asked (R5, R8)
    task automatic run_op(input logic [N*B-1:0] s, input bit poke);
        last_exp = ref_dot(s);
        exp_q.push_back(last_exp);
        samples = s;
        start = 1;
        @(negedge clk);
        start = 0;
        check("R2 busy after start", int'(busy), 1);
        for (int k = 1; k < B; k++) begin
            if (poke && k == 3) begin
                samples = ~s;
                start = 1;
            end else if (poke && k == 4) begin
                start = 0;
            end
            @(negedge clk);
            if (k == B-1) check("R2 no early done", int'(done), 0);
        end
        start = 0;
        @(negedge clk);
        check("R2 done after B cycles", int'(done), 1);
        check("R2 busy low with done", int'(busy), 0);
        samples = ~samples;
        @(negedge clk);
        check("R2 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R6 result held", int'(result), last_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 result reset", int'(result), 0);

        run_op({N{8'h80}}, 0);                 // R4 all most negative
        run_op({N{8'h7F}}, 0);                 // R3 all most positive
        // R3 extreme mixed signs: negative weights meet -128, others +127
        run_op({8'h7F, 8'h80, 8'h7F, 8'h7F, 8'h80, 8'h7F, 8'h80, 8'h7F}, 0);
        run_op({8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01}, 0); // R7 lane 0 only
        run_op({8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0); // R7 lane 7 only
        run_op({N{8'h80}}, 1);                 // R5 R8 disturbed run
        for (int r = 0; r < 20; r++)
            run_op({$urandom(), $urandom()}, (r % 4) == 1);
        repeat (4) @(negedge clk);
        check("R5 no leftover results", exp_q.size(), 0);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule